// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 32 level-sensitive interrupt lines and steers each one to a normal interrupt output or to a fast interrupt output. Software controls the block over a simple register bus with single-cycle read and write strobes. Per-source enable bits and software-raised request bits each have one address that sets bits and another address that clears them. A software-raised bit requests service in exactly the same way as the external line.

Requests on the normal path are vectored. Sixteen slots each hold a source number and a handler address, and slot 0 has the highest priority. A source that no enabled slot claims falls back to a default handler address, which takes a seventeenth priority level below every slot. When the handler register is read, the block returns the winning address and marks that level as in service. Further requests at that level or a lower one are then held off until software writes the handler register, and that write retires the most urgent level in service. Reading and writing this register in turn unwinds nested service.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `irq_o` and `fiq_o` are low, and the enable (read at 0x010), route-select (0x00C) and software-request (0x018) registers read 0.
- R2: A write to 0x010 sets every enable bit that is 1 in the data, and a write to 0x014 clears every enable bit that is 1 in the data. Bits written as 0 keep their value.
- R3: A write to 0x018 sets software-request bits and a write to 0x01C clears them, with the same 1-only rule. Raw status at 0x008 is the OR of `src_i` and the software-request bits.
- R4: Route-select bit n set to 1 sends source n to the fast path. Normal status at 0x000 is raw & enable & ~select, fast status at 0x004 is raw & enable & select, and `fiq_o` is high when fast status is non-zero.
- R5: The control word of slot k is at 0x200+4k, with bit 5 as the slot enable and bits 4:0 as the source number. Its handler address is at 0x100+4k. Reading 0x030 returns the handler address of the lowest-numbered enabled slot whose source has a normal-status bit set.
- R6: When normal status is non-zero but no enabled slot claims a pending source, reading 0x030 returns the default address held at 0x034.
- R7: A read of 0x030 that returns an eligible request marks its level as in service. Afterwards, requests at that level or a lower one drive `irq_o` low and make 0x030 return the default address without changing the service state, while a more urgent slot still raises `irq_o` and can be taken.
- R8: A write of any value to 0x030 retires the most urgent level in service, which lets the next-lower pending level raise `irq_o` again.
- R9: Reading 0xFE0+4i (i = 0..3) returns byte i of the identification parameter in bits 7:0, with the upper bits 0. Bits 19:12 of the assembled little-endian word form the vendor code.
- R10: Bit 0 of the protection register (0x020) and of the test control register (0x300) store the written value and read back. Writing 0 to 0x300 selects normal operation.
- R11: `irq_o` and `fiq_o` are registered and change one clock after the state or input that causes the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of `rd_i` |
| src_i | input | 32 | Level-sensitive interrupt lines |
| irq_o | output | 1 | Normal interrupt request, active high |
| fiq_o | output | 1 | Fast interrupt request, active high |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle and that each access lasts exactly one cycle. The bench's access tasks raise one strobe for one clock and return it low before the next access. The service-level checks also assume that `src_i` does not change in the cycle of a handler read. The stimulus changes `src_i` only at falling edges between accesses, so every take and retire acts on the request that was visible when the read data was sampled.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned AW = 12;
  localparam logic [AW-1:0] OFF_IRQ_STAT  = 12'h000;
  localparam logic [AW-1:0] OFF_FIQ_STAT  = 12'h004;
  localparam logic [AW-1:0] OFF_RAW       = 12'h008;
  localparam logic [AW-1:0] OFF_SEL       = 12'h00C;
  localparam logic [AW-1:0] OFF_EN_SET    = 12'h010;
  localparam logic [AW-1:0] OFF_EN_CLR    = 12'h014;
  localparam logic [AW-1:0] OFF_SW_SET    = 12'h018;
  localparam logic [AW-1:0] OFF_SW_CLR    = 12'h01C;
  localparam logic [AW-1:0] OFF_PROT      = 12'h020;
  localparam logic [AW-1:0] OFF_VEC       = 12'h030;
  localparam logic [AW-1:0] OFF_DEF       = 12'h034;
  localparam logic [AW-1:0] OFF_SLOT_ADDR = 12'h100;
  localparam logic [AW-1:0] OFF_SLOT_CTL  = 12'h200;
  localparam logic [AW-1:0] OFF_TEST      = 12'h300;
  localparam logic [AW-1:0] OFF_ID        = 12'hFE0;
  localparam int unsigned   ID_BYTES      = 4;
endpackage

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
  import irq_vec_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned SW    = $clog2(NSRC)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [DW-1:0]               wdata_i,
  output logic [NSRC-1:0]             en_o,
  output logic [NSRC-1:0]             sel_o,
  output logic [NSRC-1:0]             soft_o,
  output logic [NSLOT-1:0]            slot_en_o,
  output logic [NSLOT-1:0][SW-1:0]    slot_src_o,
  output logic [NSLOT-1:0][DW-1:0]    slot_addr_o,
  output logic [DW-1:0]               def_addr_o,
  output logic                        prot_o,
  output logic                        test_o
);
  logic [NSRC-1:0] wbits;
  assign wbits = wdata_i[NSRC-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= '0;
      sel_o      <= '0;
      soft_o     <= '0;
      def_addr_o <= '0;
      prot_o     <= 1'b0;
      test_o     <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == OFF_SEL)    sel_o      <= wbits;
      if (addr_i == OFF_EN_SET) en_o       <= en_o | wbits;
      if (addr_i == OFF_EN_CLR) en_o       <= en_o & ~wbits;
      if (addr_i == OFF_SW_SET) soft_o     <= soft_o | wbits;
      if (addr_i == OFF_SW_CLR) soft_o     <= soft_o & ~wbits;
      if (addr_i == OFF_DEF)    def_addr_o <= wdata_i;
      if (addr_i == OFF_PROT)   prot_o     <= wdata_i[0];
      if (addr_i == OFF_TEST)   test_o     <= wdata_i[0];
    end
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam logic [AW-1:0] A_ADDR = OFF_SLOT_ADDR + AW'(4 * k);
    localparam logic [AW-1:0] A_CTL  = OFF_SLOT_CTL + AW'(4 * k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_en_o[k]   <= 1'b0;
        slot_src_o[k]  <= '0;
        slot_addr_o[k] <= '0;
      end else if (wr_i) begin
        if (addr_i == A_ADDR) slot_addr_o[k] <= wdata_i;
        if (addr_i == A_CTL) begin
          slot_en_o[k]  <= wdata_i[SW];
          slot_src_o[k] <= wdata_i[SW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  parameter int unsigned SW    = $clog2(NSRC),
  parameter int unsigned LW    = $clog2(NSLOT + 2)
) (
  input  logic [NSRC-1:0]          irq_stat_i,
  input  logic [NSLOT-1:0]         slot_en_i,
  input  logic [NSLOT-1:0][SW-1:0] slot_src_i,
  input  logic [LW-1:0]            cur_lvl_i,
  output logic [LW-1:0]            best_lvl_o,
  output logic                     req_ok_o
);
  logic [NSLOT-1:0] hit;
  logic [NSRC-1:0]  claimed;

  for (genvar k = 0; k < NSLOT; k++) begin : g_hit
    assign hit[k] = slot_en_i[k] & irq_stat_i[slot_src_i[k]];
  end

  always_comb begin
    claimed = '0;
    for (int k = 0; k < NSLOT; k++)
      if (slot_en_i[k]) claimed[slot_src_i[k]] = 1'b1;
  end

  // lowest slot index wins; unclaimed sources fall to the default level
  always_comb begin
    best_lvl_o = LW'(NSLOT + 1);
    if (|(irq_stat_i & ~claimed)) best_lvl_o = LW'(NSLOT);
    for (int k = NSLOT - 1; k >= 0; k--)
      if (hit[k]) best_lvl_o = LW'(k);
  end

  assign req_ok_o = best_lvl_o < cur_lvl_i;
endmodule

// File: rtl/irq_vec_stack.sv
module irq_vec_stack #(
  parameter int unsigned NLVL = 17,
  parameter int unsigned LW   = $clog2(NLVL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [LW-1:0]   push_lvl_i,
  input  logic            pop_i,
  output logic [NLVL-1:0] isr_o,
  output logic [LW-1:0]   cur_lvl_o
);
  logic [NLVL-1:0] isr_d;

  always_comb begin
    cur_lvl_o = LW'(NLVL);
    for (int k = NLVL - 1; k >= 0; k--)
      if (isr_o[k]) cur_lvl_o = LW'(k);
  end

  always_comb begin
    isr_d = isr_o;
    for (int k = 0; k < NLVL; k++) begin
      if (pop_i && cur_lvl_o == LW'(k))   isr_d[k] = 1'b0;
      if (push_i && push_lvl_i == LW'(k)) isr_d[k] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_o <= '0;
    else         isr_o <= isr_d;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned NSLOT  = 16,
  parameter int unsigned DW     = 32,
  parameter logic [31:0] ID_VAL = 32'h1052_7C3D
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NSRC-1:0] src_i,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int unsigned SW   = $clog2(NSRC);
  localparam int unsigned NLVL = NSLOT + 1;
  localparam int unsigned LW   = $clog2(NSLOT + 2);

  logic [NSRC-1:0]          en_w, sel_w, soft_w;
  logic [NSLOT-1:0]         slot_en_w;
  logic [NSLOT-1:0][SW-1:0] slot_src_w;
  logic [NSLOT-1:0][DW-1:0] slot_addr_w;
  logic [DW-1:0]            def_addr_w, vec_data;
  logic                     prot_w, test_w;
  logic [NSRC-1:0]          raw, irq_stat, fiq_stat;
  logic                     fiq_any, req_ok, take, ack;
  logic [LW-1:0]            best_lvl, cur_lvl;
  logic [NLVL-1:0]          isr_w;

  irq_vec_regs #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW), .SW(SW)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .en_o(en_w), .sel_o(sel_w), .soft_o(soft_w),
    .slot_en_o(slot_en_w), .slot_src_o(slot_src_w), .slot_addr_o(slot_addr_w),
    .def_addr_o(def_addr_w), .prot_o(prot_w), .test_o(test_w)
  );

  assign raw      = src_i | soft_w;
  assign irq_stat = raw & en_w & ~sel_w;
  assign fiq_stat = raw & en_w & sel_w;
  assign fiq_any  = |fiq_stat;

  irq_vec_arb #(.NSRC(NSRC), .NSLOT(NSLOT), .SW(SW), .LW(LW)) u_arb (
    .irq_stat_i(irq_stat), .slot_en_i(slot_en_w), .slot_src_i(slot_src_w),
    .cur_lvl_i(cur_lvl), .best_lvl_o(best_lvl), .req_ok_o(req_ok)
  );

  assign take = rd_i && (addr_i == OFF_VEC) && req_ok;
  assign ack  = wr_i && (addr_i == OFF_VEC);

  irq_vec_stack #(.NLVL(NLVL), .LW(LW)) u_stack (
    .clk_i, .rst_ni, .push_i(take), .push_lvl_i(best_lvl), .pop_i(ack),
    .isr_o(isr_w), .cur_lvl_o(cur_lvl)
  );

  always_comb begin
    vec_data = def_addr_w;
    for (int k = 0; k < NSLOT; k++)
      if (req_ok && best_lvl == LW'(k)) vec_data = slot_addr_w[k];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_IRQ_STAT: rdata_o = DW'(irq_stat);
      OFF_FIQ_STAT: rdata_o = DW'(fiq_stat);
      OFF_RAW:      rdata_o = DW'(raw);
      OFF_SEL:      rdata_o = DW'(sel_w);
      OFF_EN_SET:   rdata_o = DW'(en_w);
      OFF_SW_SET:   rdata_o = DW'(soft_w);
      OFF_PROT:     rdata_o = DW'(prot_w);
      OFF_VEC:      rdata_o = vec_data;
      OFF_DEF:      rdata_o = def_addr_w;
      OFF_TEST:     rdata_o = DW'(test_w);
      default:      ;
    endcase
    for (int k = 0; k < NSLOT; k++) begin
      if (addr_i == OFF_SLOT_ADDR + AW'(4 * k)) rdata_o = slot_addr_w[k];
      if (addr_i == OFF_SLOT_CTL + AW'(4 * k))  rdata_o = DW'({slot_en_w[k], slot_src_w[k]});
    end
    for (int k = 0; k < ID_BYTES; k++)
      if (addr_i == OFF_ID + AW'(4 * k)) rdata_o = DW'(ID_VAL[8*k +: 8]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= req_ok;
      fiq_o <= fiq_any;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
  import irq_vec_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned NLVL = 17,
  parameter int unsigned DW   = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rd_i,
  input logic            wr_i,
  input logic [AW-1:0]   addr_i,
  input logic [DW-1:0]   wdata_i,
  input logic            irq_o,
  input logic            fiq_o,
  input logic [NSRC-1:0] en_i,
  input logic            fiq_any_i,
  input logic            req_ok_i,
  input logic [NLVL-1:0] isr_i
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!irq_o && !fiq_o));

  assert_en_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_EN_SET) |=> ((en_i & $past(wdata_i[NSRC-1:0])) == $past(wdata_i[NSRC-1:0])));

  assert_en_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_EN_CLR) |=> ((en_i & $past(wdata_i[NSRC-1:0])) == '0));

  assert_fiq_path_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o == $past(fiq_any_i));

  assert_irq_timing_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(req_ok_i));

  assert_take_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == OFF_VEC && req_ok_i) |=> $countones(isr_i) == $countones($past(isr_i)) + 1);

  assert_ack_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && addr_i == OFF_VEC && isr_i != '0) |=> $countones(isr_i) + 1 == $countones($past(isr_i)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NSRC(NSRC), .NLVL(NSLOT + 1), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .fiq_o(fiq_o), .en_i(en_w),
  .fiq_any_i(fiq_any), .req_ok_i(req_ok), .isr_i(isr_w)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, src = '0;
  logic        irq, fiq;

  int compared = 0, mismatched = 0;
  logic [31:0] act_q[$], exp_q[$];
  string       tag_q[$];
  logic [31:0] m_act, m_exp;
  string       m_tag;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic push(input logic [31:0] act, input logic [31:0] exp, input string tag);
    act_q.push_back(act);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1;
    push(rdata, exp, tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pins_now(input logic ei, input logic ef, input string tag);
    #1;
    push({31'b0, irq}, {31'b0, ei}, {tag, " irq_o"});
    push({31'b0, fiq}, {31'b0, ef}, {tag, " fiq_o"});
  endtask

  task automatic pins(input logic ei, input logic ef, input string tag);
    @(negedge clk);
    pins_now(ei, ef, tag);
  endtask

  task automatic drive_src(input logic [31:0] v);
    @(negedge clk);
    src = v;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (act_q.size() != 0) begin
      m_act = act_q.pop_front();
      m_exp = exp_q.pop_front();
      m_tag = tag_q.pop_front();
      compared++;
      if (m_act !== m_exp) begin
        mismatched++;
        $display("FAIL %s actual=%h expected=%h", m_tag, m_act, m_exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pins(1'b0, 1'b0, "R1 reset");
    rd_chk(12'h010, 32'h0, "R1 enable reset");
    rd_chk(12'h00C, 32'h0, "R1 select reset");
    rd_chk(12'h018, 32'h0, "R1 soft reset");

    wr_reg(12'h010, 32'h0000_00F0);
    wr_reg(12'h010, 32'h0000_0300);
    rd_chk(12'h010, 32'h0000_03F0, "R2 set accumulates");
    wr_reg(12'h014, 32'h0000_0110);
    rd_chk(12'h010, 32'h0000_02E0, "R2 clear only ones");

    wr_reg(12'h018, 32'h0000_0020);
    pins_now(1'b0, 1'b0, "R11 one cycle latency");
    pins(1'b1, 1'b0, "R11 after latency");
    rd_chk(12'h018, 32'h0000_0020, "R3 soft set");
    rd_chk(12'h008, 32'h0000_0020, "R3 raw from soft");
    rd_chk(12'h000, 32'h0000_0020, "R4 irq status from soft");
    wr_reg(12'h01C, 32'h0000_0021);
    rd_chk(12'h018, 32'h0000_0000, "R3 soft clear");

    drive_src(32'h0000_00C0);
    wr_reg(12'h00C, 32'h0000_0080);
    rd_chk(12'h000, 32'h0000_0040, "R4 irq status");
    rd_chk(12'h004, 32'h0000_0080, "R4 fiq status");
    rd_chk(12'h008, 32'h0000_00C0, "R3 raw from line");
    rd_chk(12'h00C, 32'h0000_0080, "R4 select readback");
    pins(1'b1, 1'b1, "R4 both outputs");
    drive_src(32'h0);
    wr_reg(12'h00C, 32'h0);
    pins(1'b0, 1'b0, "R4 outputs drop");

    wr_reg(12'h208, 32'h0000_0029);
    wr_reg(12'h108, 32'hA000_0002);
    wr_reg(12'h21C, 32'h0000_0026);
    wr_reg(12'h11C, 32'hA000_0007);
    wr_reg(12'h210, 32'h0000_0005);
    wr_reg(12'h110, 32'hA000_0004);
    wr_reg(12'h034, 32'hD0D0_0000);
    rd_chk(12'h208, 32'h0000_0029, "R5 slot control readback");
    rd_chk(12'h210, 32'h0000_0005, "R5 disabled slot readback");
    rd_chk(12'h11C, 32'hA000_0007, "R5 slot address readback");
    rd_chk(12'h034, 32'hD0D0_0000, "R6 default readback");

    drive_src(32'h0000_0040);
    pins(1'b1, 1'b0, "R5 vectored request");
    rd_chk(12'h030, 32'hA000_0007, "R5 slot 7 vector");
    pins(1'b0, 1'b0, "R7 level 7 in service");
    drive_src(32'h0000_0060);
    pins(1'b0, 1'b0, "R7 lower request masked");
    rd_chk(12'h030, 32'hD0D0_0000, "R7 masked read gives default");
    drive_src(32'h0000_0260);
    pins(1'b1, 1'b0, "R7 higher slot preempts");
    rd_chk(12'h030, 32'hA000_0002, "R5 slot 2 wins");
    pins(1'b0, 1'b0, "R7 level 2 in service");

    drive_src(32'h0000_0060);
    wr_reg(12'h030, 32'h0);
    pins(1'b0, 1'b0, "R8 ack leaves level 7");
    wr_reg(12'h030, 32'h1234_5678);
    pins(1'b1, 1'b0, "R8 stack empty");
    rd_chk(12'h030, 32'hA000_0007, "R8 slot 7 retaken");
    wr_reg(12'h030, 32'h0);

    drive_src(32'h0000_0020);
    rd_chk(12'h000, 32'h0000_0020, "R6 unclaimed status");
    rd_chk(12'h030, 32'hD0D0_0000, "R6 default vector");
    pins(1'b0, 1'b0, "R7 default level in service");
    wr_reg(12'h030, 32'h0);
    pins(1'b1, 1'b0, "R8 default retired");
    drive_src(32'h0);

    rd_chk(12'hFE0, 32'h0000_003D, "R9 id byte 0");
    rd_chk(12'hFE4, 32'h0000_007C, "R9 id byte 1");
    rd_chk(12'hFE8, 32'h0000_0052, "R9 id byte 2");
    rd_chk(12'hFEC, 32'h0000_0010, "R9 id byte 3");

    wr_reg(12'h020, 32'hFFFF_FFFF);
    rd_chk(12'h020, 32'h0000_0001, "R10 protection bit");
    wr_reg(12'h300, 32'h0000_0001);
    rd_chk(12'h300, 32'h0000_0001, "R10 test bit set");
    wr_reg(12'h300, 32'h0);
    rd_chk(12'h300, 32'h0000_0000, "R10 test normal");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule